// File: doc/BRIEF.md
# Password-Gated Manual Trigger Decoder

This block decodes a write-only byte command field into single-cycle trigger strobes for six output channels. The field has two roles. First it takes a fixed four-byte password, 0xDE, 0xAD, 0xBE and 0xEF, in that exact order. Once the password is complete, the next byte written is read as a channel number. A value from 1 to 6 fires a one-cycle trigger on that channel's line. Every other value fires nothing.

A complete trigger therefore takes five accepted byte writes. After the channel byte, whether it was valid or not, the password must be entered again. The bus side is reduced to a write strobe, a field-select flag and the byte being written. The field-select flag tells this field apart from other fields of the same control register. Writes with the flag low leave the sequence untouched. Downstream pulse-shaping logic takes the trigger strobes.

Top module: `manual_trigger_unlock`

## Requirements
- R1: While rst_ni is low, and on the first cycles after it is released, trig_o is all zero. A password that is partly or fully entered before a reset is forgotten.
- R2: Accepted writes (wr_en_i and field_sel_i both high) of 0xDE, 0xAD, 0xBE, 0xEF in that order arm the decoder for one channel byte.
- R3: A wrong byte during password entry returns the decoder to its start state. If that wrong byte is 0xDE, it counts as the first password byte.
- R4: In the armed state, an accepted channel byte N from 1 to 6 sets trig_o bit N-1. This is the only bit set, and it is high for exactly the one cycle that follows the clock edge that captured the write.
- R5: In the armed state, an accepted channel byte of 0 or above 6 sets no trig_o bit and returns the decoder to its start state.
- R6: After any channel byte, valid or not, a further channel byte triggers nothing until the full password has been written again.
- R7: A write with field_sel_i low neither advances nor resets the sequence, and never triggers.
- R8: trig_o stays zero in any cycle that does not follow an accepted channel write in the armed state. Cycles with wr_en_i low change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Byte write strobe, one cycle per write |
| field_sel_i | input | 1 | High when the write targets the trigger field |
| wr_data_i | input | 8 | Byte written to the field |
| trig_o | output | 6 | One-hot trigger strobes, bit N-1 for channel N |

## Verification
The only result is trig_o. It comes from one register, so a channel byte captured at a clock edge shows on trig_o right after that edge and clears at the next edge. Password bytes produce no result at all. The bench drives each write at a falling edge and samples trig_o at the next falling edge, which is half a cycle after the capturing edge. One more falling-edge sample then confirms that the strobe has dropped. Internal sequence progress is observed only through whether a later channel byte fires, so each ignored or resetting stimulus is followed by a channel byte whose outcome is checked.

// File: rtl/mpt_pkg.sv
package mpt_pkg;
  localparam int BYTE_W = 8;
  typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/mpt_seq_fsm.sv
module mpt_seq_fsm #(
  parameter int PW_LEN = 4,
  parameter logic [PW_LEN*mpt_pkg::BYTE_W-1:0] PW_WORD = 32'hDEADBEEF
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_hit_i,
  input  mpt_pkg::byte_t      wr_data_i,
  output logic                armed_o,
  output logic                accept_o
);
  import mpt_pkg::*;

  localparam int STG_W = $clog2(PW_LEN + 1);
  localparam int IDX_W = (PW_LEN > 1) ? $clog2(PW_LEN) : 1;
  localparam logic [STG_W-1:0] STG_ARMED = STG_W'(PW_LEN);

  byte_t            pw_bytes [PW_LEN];
  logic [STG_W-1:0] stage_q, stage_d;
  logic [IDX_W-1:0] idx;

  // password byte 0 is the most significant byte of PW_WORD
  for (genvar i = 0; i < PW_LEN; i++) begin : g_pw
    assign pw_bytes[i] = PW_WORD[(PW_LEN-1-i)*BYTE_W +: BYTE_W];
  end

  assign armed_o  = (stage_q == STG_ARMED);
  assign accept_o = wr_hit_i && armed_o;
  assign idx      = stage_q[IDX_W-1:0];

  always_comb begin
    stage_d = stage_q;
    if (wr_hit_i) begin
      if (armed_o)                        stage_d = '0;
      else if (wr_data_i == pw_bytes[idx]) stage_d = stage_q + STG_W'(1);
      else if (wr_data_i == pw_bytes[0])  stage_d = STG_W'(1);
      else                                stage_d = '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stage_q <= '0;
    else         stage_q <= stage_d;
  end
endmodule

// File: rtl/mpt_chan_decode.sv
module mpt_chan_decode #(
  parameter int NUM_CH = 6
) (
  input  mpt_pkg::byte_t    chan_i,
  output logic [NUM_CH-1:0] onehot_o,
  output logic              valid_o
);
  import mpt_pkg::*;

  // channel numbers are 1-based
  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    assign onehot_o[i] = (chan_i == BYTE_W'(i + 1));
  end

  assign valid_o = |onehot_o;
endmodule

// File: rtl/manual_trigger_unlock.sv
module manual_trigger_unlock #(
  parameter int NUM_CH = 6,
  parameter int PW_LEN = 4,
  parameter logic [PW_LEN*mpt_pkg::BYTE_W-1:0] PW_WORD = 32'hDEADBEEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              field_sel_i,
  input  logic [7:0]        wr_data_i,
  output logic [NUM_CH-1:0] trig_o
);
  logic              wr_hit;
  logic              armed;
  logic              accept;
  logic [NUM_CH-1:0] onehot;
  logic              valid;
  logic [NUM_CH-1:0] trig_q, trig_d;

  assign wr_hit = wr_en_i && field_sel_i;

  mpt_seq_fsm #(
    .PW_LEN (PW_LEN),
    .PW_WORD(PW_WORD)
  ) u_fsm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_hit_i (wr_hit),
    .wr_data_i(wr_data_i),
    .armed_o  (armed),
    .accept_o (accept)
  );

  mpt_chan_decode #(
    .NUM_CH(NUM_CH)
  ) u_dec (
    .chan_i  (wr_data_i),
    .onehot_o(onehot),
    .valid_o (valid)
  );

  assign trig_d = (accept && valid) ? onehot : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) trig_q <= '0;
    else         trig_q <= trig_d;
  end

  assign trig_o = trig_q;
endmodule

// File: rtl/mpt_checker.sv
module mpt_checker #(
  parameter int NUM_CH = 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic              field_sel_i,
  input logic [7:0]        wr_data_i,
  input logic              armed,
  input logic [NUM_CH-1:0] trig_o
);
  // R1
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      p_reset_quiet_r1: assert (trig_o == '0);
    end
  end

  p_onehot_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(trig_o));

  p_single_cycle_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trig_o != '0) |=> (trig_o == '0));

  p_chan_match_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trig_o != '0) |-> (trig_o == (NUM_CH'(1) << ($past(wr_data_i) - 8'd1))));

  p_bad_chan_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && field_sel_i && (wr_data_i == 8'd0 || wr_data_i > 8'(NUM_CH)))
      |=> (trig_o == '0));

  p_rearm_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && field_sel_i && armed) |=> !armed);

  p_other_field_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !field_sel_i) |=> (trig_o == '0 && armed == $past(armed)));

  p_idle_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> (trig_o == '0 && $stable(armed)));

  p_arm_needs_write_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(armed) |-> $past(wr_en_i && field_sel_i));
endmodule

bind manual_trigger_unlock mpt_checker #(.NUM_CH(NUM_CH)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wr_en_i    (wr_en_i),
  .field_sel_i(field_sel_i),
  .wr_data_i  (wr_data_i),
  .armed      (armed),
  .trig_o     (trig_o)
);

// File: tb/manual_trigger_unlock_test.sv
module manual_trigger_unlock_test;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 8;

  typedef struct packed {
    logic [5:0][7:0] bytes;
    logic [5:0]      exp;
  } vec_t;

  // bytes[5] is written first; exp is checked after bytes[0]
  localparam vec_t VECS [NV] = '{
    '{bytes: {8'h00, 8'hDE, 8'hAD, 8'hBE, 8'hEF, 8'h01}, exp: 6'b000001},
    '{bytes: {8'h00, 8'hDE, 8'hAD, 8'hBE, 8'hEF, 8'h06}, exp: 6'b100000},
    '{bytes: {8'hDE, 8'hDE, 8'hAD, 8'hBE, 8'hEF, 8'h04}, exp: 6'b001000},
    '{bytes: {8'h00, 8'hDE, 8'hAD, 8'hBE, 8'hEF, 8'h00}, exp: 6'b000000},
    '{bytes: {8'h00, 8'hDE, 8'hAD, 8'hBE, 8'hEF, 8'h07}, exp: 6'b000000},
    '{bytes: {8'h00, 8'hDE, 8'hAD, 8'hBE, 8'hEF, 8'hDE}, exp: 6'b000000},
    '{bytes: {8'hDE, 8'hAD, 8'hEF, 8'hBE, 8'hEF, 8'h01}, exp: 6'b000000},
    '{bytes: {8'hDE, 8'hAD, 8'hBE, 8'hDE, 8'hEF, 8'h02}, exp: 6'b000000}
  };
  localparam string VREQ [NV] = '{"R4", "R4", "R3", "R5", "R5", "R5", "R3", "R3"};

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic       sel = 1'b0;
  logic [7:0] data = 8'h00;
  logic [5:0] trig;
  int         total = 0;
  int         fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  manual_trigger_unlock uut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .wr_en_i    (wr_en),
    .field_sel_i(sel),
    .wr_data_i  (data),
    .trig_o     (trig)
  );

  task automatic chk(input string req, input logic [5:0] act, input logic [5:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: trig_o=%b expected %b", req, act, exp);
    end
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic wr(input logic s, input logic [7:0] d);
    wr_en = 1'b1; sel = s; data = d;
    @(negedge clk);
    wr_en = 1'b0; sel = 1'b0; data = 8'h5A;
  endtask

  task automatic unlock(input string req);
    wr(1'b1, 8'hDE); chk(req, trig, '0);
    wr(1'b1, 8'hAD); chk(req, trig, '0);
    wr(1'b1, 8'hBE); chk(req, trig, '0);
    wr(1'b1, 8'hEF); chk(req, trig, '0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog: trig_o=%b expected run to end", trig);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1 in reset", trig, '0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after reset", trig, '0);

    // table walk: R2..R5
    for (int v = 0; v < NV; v++) begin
      wr(1'b1, 8'h00); chk("flush", trig, '0);
      for (int b = 5; b >= 1; b--) begin
        wr(1'b1, VECS[v].bytes[b]);
        chk(VREQ[v], trig, '0);
      end
      wr(1'b1, VECS[v].bytes[0]);
      chk(VREQ[v], trig, VECS[v].exp);
      @(negedge clk);
      chk("R4 single cycle", trig, '0);
    end

    // R2: in-order password then channel 3
    wr(1'b1, 8'h00);
    unlock("R2");
    wr(1'b1, 8'h03); chk("R2 armed by password", trig, 6'b000100);

    // R3: overlapping restart DE AD DE AD BE EF
    wr(1'b1, 8'hDE); wr(1'b1, 8'hAD);
    unlock("R3");
    wr(1'b1, 8'h05); chk("R3 restart on DE", trig, 6'b010000);

    // R6: second channel byte after trigger does nothing
    unlock("R6");
    wr(1'b1, 8'h02); chk("R6 first channel", trig, 6'b000010);
    wr(1'b1, 8'h02); chk("R6 repeat channel", trig, '0);
    unlock("R6");
    wr(1'b1, 8'h00); chk("R6 invalid channel", trig, '0);
    wr(1'b1, 8'h01); chk("R6 after invalid channel", trig, '0);

    // R7: other-field writes neither advance nor reset
    wr(1'b1, 8'hDE); wr(1'b0, 8'h00);
    wr(1'b1, 8'hAD); wr(1'b0, 8'hAD);
    wr(1'b1, 8'hBE); wr(1'b0, 8'h13);
    wr(1'b1, 8'hEF);
    wr(1'b0, 8'h01); chk("R7 other field while armed", trig, '0);
    wr(1'b1, 8'h01); chk("R7 sequence kept", trig, 6'b000001);
    wr(1'b0, 8'hDE); wr(1'b0, 8'hAD); wr(1'b0, 8'hBE); wr(1'b0, 8'hEF);
    wr(1'b1, 8'h06); chk("R7 other field cannot unlock", trig, '0);

    // R8: idle cycles hold the armed state
    unlock("R8");
    data = 8'h02; sel = 1'b1;
    repeat (4) begin
      @(negedge clk);
      chk("R8 no strobe", trig, '0);
    end
    sel = 1'b0;
    wr(1'b1, 8'h04); chk("R8 armed kept", trig, 6'b001000);

    // R1: reset forgets a full password
    unlock("R1");
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    wr(1'b1, 8'h01); chk("R1 reset clears armed", trig, '0);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule